// File: doc/BRIEF.md
# Thermal Sensor Register Target on a Two-Wire Bus

This block is the bus side of a temperature monitor. It listens to an I2C bus as a target, sampling SCL and SDA with the system clock, and serves four registers chosen by a pointer byte. The four registers are a read-only temperature word fed from the sensor path, an 8-bit configuration byte, and two 16-bit thermostat setpoints (low and high). The configuration and setpoints drive the thermostat logic next to it.

A bus master first sends the address byte. For a write it then sends a pointer byte, followed by one data byte for the configuration register or two data bytes for a setpoint. The pointer keeps its value after STOP, so a master can read the same register many times without sending the pointer again. Reads return data MSB first, high byte first for 16-bit registers. A one-cycle strobe marks each complete register read, and the thermostat treats it as its alarm clear event.

Top module: `therm_i2c_target`

## Requirements
- R1: The target acknowledges an address byte only when its top four bits are 1001 and bits 3:1 equal `addr_sel`. Bit 0 selects the direction (1 = read, 0 = write). Any other address is not acknowledged, and the rest of that transaction is ignored.
- R2: A pointer byte of 00h to 03h is acknowledged and selects a register: 00h temperature, 01h configuration, 02h low setpoint, 03h high setpoint. A larger pointer is not acknowledged and leaves the pointer unchanged.
- R3: The pointer resets to 00h and keeps its value across STOP, so a read with no new pointer returns the register selected last.
- R4: A write to the configuration register takes one data byte. Bit 7 is stored as 0 and bits 6:0 as sent, visible on `cfg_out`. A second data byte in the same transaction is not acknowledged. The reset value is 00h.
- R5: A setpoint write takes two data bytes, high byte first. The register changes only when the second byte arrives, and a third byte is not acknowledged. The low setpoint resets to 4B00h and the high setpoint to 5000h.
- R6: Data bytes written with the pointer at 00h are not acknowledged and change no register.
- R7: Read data leaves MSB first, high byte first for 16-bit registers. The low byte of a temperature read is the value captured together with the high byte, even if `temp_value` changes between the two bytes. A read of the configuration register repeats the byte.
- R8: After the master NACKs a read byte, the target releases SDA and ignores the bus until the next START.
- R9: `rd_strobe` pulses for one cycle each time the last byte of a register (two bytes for 16-bit registers, one for configuration) has been read. A read that ends after only the high byte gives no pulse.
- R10: A repeated START at any point restarts address recognition, so a pointer write followed by a repeated START and a read returns the newly selected register.
- R11: `sda_drive_low` is 0 during reset and after every STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| addr_sel | input | 3 | Strap value for address bits 3:1 |
| temp_value | input | 16 | Latest conversion result, two's complement |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_out | output | 8 | Configuration byte |
| set_lo | output | 16 | Low thermostat setpoint |
| set_hi | output | 16 | High thermostat setpoint |
| rd_strobe | output | 1 | One-cycle pulse per completed register read |

## Verification
The bench targets byte counting per register. A design that treats every register as two bytes would acknowledge a second configuration byte, and one that commits a setpoint early would show a half-written value after a single byte followed by STOP. It also goes after pointer handling: out-of-range pointers, pointer persistence over STOP, and a repeated START right after the pointer byte. A faulty pointer would read back the wrong register. Temperature values change in the middle of a read, to catch a design that returns a torn high/low pair. Partial and full reads are mixed so that a misplaced or missing `rd_strobe` changes the pulse count.

// File: rtl/therm_i2c_pkg.sv
package therm_i2c_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} bus_state_e;
  typedef enum logic [1:0] {RX_ADDR, RX_PTR, RX_DATA} rx_kind_e;
  localparam logic [1:0] SEL_TEMP = 2'd0;
  localparam logic [1:0] SEL_CFG  = 2'd1;
  localparam logic [1:0] SEL_LO   = 2'd2;
  localparam logic [1:0] SEL_HI   = 2'd3;
  localparam logic [3:0] DEV_CODE = 4'b1001;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int TOP = SYNC_STAGES - 1;
  logic [TOP:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[TOP-1:0], scl_in};
      sda_ff <= {sda_ff[TOP-1:0], sda_in};
      scl_p  <= scl_ff[TOP];
      sda_p  <= sda_ff[TOP];
    end
  end

  assign scl_s     = scl_ff[TOP];
  assign sda_s     = sda_ff[TOP];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/therm_reg_bank.sv
module therm_reg_bank
  import therm_i2c_pkg::*;
#(
  parameter logic [15:0] LO_RESET = 16'h4B00,
  parameter logic [15:0] HI_RESET = 16'h5000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_hi,
  input  logic [1:0]  wr_sel,
  input  logic [7:0]  wr_data,
  input  logic [1:0]  rd_sel,
  input  logic [15:0] temp_value,
  output logic [15:0] rd_word,
  output logic [7:0]  cfg_q,
  output logic [15:0] set_lo_q,
  output logic [15:0] set_hi_q
);
  logic [7:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      set_lo_q <= LO_RESET;
      set_hi_q <= HI_RESET;
      stage_q  <= '0;
    end else if (wr_en) begin
      if (wr_hi) stage_q <= wr_data;
      else begin
        case (wr_sel)
          SEL_CFG: cfg_q    <= {1'b0, wr_data[6:0]};
          SEL_LO:  set_lo_q <= {stage_q, wr_data};
          SEL_HI:  set_hi_q <= {stage_q, wr_data};
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_TEMP: rd_word = temp_value;
      SEL_CFG:  rd_word = {8'h00, cfg_q};
      SEL_LO:   rd_word = set_lo_q;
      default:  rd_word = set_hi_q;
    endcase
  end

  // R4: a configuration write keeps the low seven bits and clears bit 7
  assert_cfg_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hi && wr_sel == SEL_CFG) |=> cfg_q == {1'b0, $past(wr_data[6:0])});
  // R5: setpoints move only on the second (low) byte
  assert_pair_commit_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || wr_hi) |=> ($stable(set_hi_q) && $stable(set_lo_q)));
endmodule

// File: rtl/therm_i2c_fsm.sv
module therm_i2c_fsm
  import therm_i2c_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sda_s,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_det,
  input  logic        stop_det,
  input  logic [2:0]  addr_sel,
  input  logic [15:0] rd_word,
  output logic [1:0]  ptr,
  output logic        wr_en,
  output logic        wr_hi,
  output logic [1:0]  wr_sel,
  output logic [7:0]  wr_data,
  output logic        sda_low,
  output logic        rd_strobe
);
  bus_state_e state;
  rx_kind_e   kind;
  logic [2:0] bitcnt;
  logic [7:0] shreg, lo_hold;
  logic       byte_full, go_tx, byte_idx, mack;
  logic [1:0] wcnt;
  logic       wide, last, accept;
  logic [7:0] first_byte;

  assign wide       = (ptr != SEL_CFG);
  assign last       = !wide || byte_idx;
  assign first_byte = wide ? rd_word[15:8] : rd_word[7:0];
  assign accept     = (ptr != SEL_TEMP) && (wcnt < (wide ? 2'd2 : 2'd1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; kind <= RX_ADDR; bitcnt <= '0; shreg <= '0;
      lo_hold <= '0; byte_full <= 1'b0; go_tx <= 1'b0; byte_idx <= 1'b0;
      mack <= 1'b0; wcnt <= '0; ptr <= SEL_TEMP; sda_low <= 1'b0;
      rd_strobe <= 1'b0; wr_en <= 1'b0; wr_hi <= 1'b0; wr_sel <= '0; wr_data <= '0;
    end else begin
      rd_strobe <= 1'b0;
      wr_en     <= 1'b0;
      if (start_det) begin
        state <= ST_RX; kind <= RX_ADDR; bitcnt <= '0;
        byte_full <= 1'b0; sda_low <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE; sda_low <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && !byte_full) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) byte_full <= 1'b1;
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              bitcnt    <= '0;
              state     <= ST_IDLE;
              case (kind)
                RX_ADDR: if (shreg[7:4] == DEV_CODE && shreg[3:1] == addr_sel) begin
                  sda_low <= 1'b1; state <= ST_RX_ACK; go_tx <= shreg[0]; kind <= RX_PTR;
                end
                RX_PTR: if (shreg[7:2] == 6'd0) begin
                  ptr <= shreg[1:0]; wcnt <= '0; sda_low <= 1'b1;
                  go_tx <= 1'b0; kind <= RX_DATA; state <= ST_RX_ACK;
                end
                default: if (accept) begin
                  wr_en <= 1'b1; wr_sel <= ptr; wr_data <= shreg;
                  wr_hi <= wide && (wcnt == 2'd0);
                  wcnt <= wcnt + 2'd1; sda_low <= 1'b1; go_tx <= 1'b0; state <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: if (scl_fall) begin
            bitcnt <= '0;
            if (go_tx) begin
              state <= ST_TX; byte_idx <= 1'b0; shreg <= first_byte;
              lo_hold <= rd_word[7:0]; sda_low <= ~first_byte[7];
            end else begin
              state <= ST_RX; sda_low <= 1'b0;
            end
          end
          ST_TX: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_low <= 1'b0; state <= ST_TX_ACK;
            end else begin
              shreg <= {shreg[6:0], 1'b0}; sda_low <= ~shreg[6]; bitcnt <= bitcnt + 3'd1;
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
              if (last) rd_strobe <= 1'b1;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (!mack) state <= ST_IDLE;
              else if (last) begin
                state <= ST_TX; byte_idx <= 1'b0; shreg <= first_byte;
                lo_hold <= rd_word[7:0]; sda_low <= ~first_byte[7];
              end else begin
                state <= ST_TX; byte_idx <= 1'b1; shreg <= lo_hold; sda_low <= ~lo_hold[7];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: the read strobe is a single-cycle pulse
  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> !rd_strobe);
  // R11: a STOP always frees the data line
  assert_release_stop_R11: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_low);
  // R10: any START returns to address reception
  assert_restart_addr_R10: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_RX && kind == RX_ADDR && bitcnt == 3'd0));
  // R6: the temperature register is never written
  assert_no_temp_write_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_sel != SEL_TEMP);
  // R3: the pointer holds while the bus is idle
  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |=> ptr == $past(ptr));
endmodule

// File: rtl/therm_i2c_target.sv
module therm_i2c_target #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] LO_RESET    = 16'h4B00,
  parameter logic [15:0] HI_RESET    = 16'h5000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic [2:0]  addr_sel,
  input  logic [15:0] temp_value,
  output logic        sda_drive_low,
  output logic [7:0]  cfg_out,
  output logic [15:0] set_lo,
  output logic [15:0] set_hi,
  output logic        rd_strobe
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [1:0]  ptr, wr_sel;
  logic        wr_en, wr_hi;
  logic [7:0]  wr_data;
  logic [15:0] rd_word;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  therm_i2c_fsm u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .addr_sel(addr_sel), .rd_word(rd_word),
    .ptr(ptr), .wr_en(wr_en), .wr_hi(wr_hi), .wr_sel(wr_sel), .wr_data(wr_data),
    .sda_low(sda_drive_low), .rd_strobe(rd_strobe));

  therm_reg_bank #(.LO_RESET(LO_RESET), .HI_RESET(HI_RESET)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_hi(wr_hi), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(ptr), .temp_value(temp_value), .rd_word(rd_word),
    .cfg_q(cfg_out), .set_lo_q(set_lo), .set_hi_q(set_hi));

  // R11: the line is never pulled while reset is held
  assert_reset_release_R11: assert property (@(posedge clk) rst |=> !sda_drive_low);
endmodule

// File: tb/test_therm_i2c_target.sv
module test_therm_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic [15:0] temp_value = 16'h1910;
  logic sda_drive_low, rd_strobe, sda_line;
  logic [7:0] cfg_out;
  logic [15:0] set_lo, set_hi;
  int checks = 0, errors = 0, strobes = 0;
  bit finished = 1'b0;
  logic [7:0] m_cfg = 8'h00;
  logic [15:0] m_lo = 16'h4B00, m_hi = 16'h5000;
  logic [1:0] m_ptr = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_drive_low;

  therm_i2c_target i_therm_i2c_target (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .addr_sel(STRAP),
    .temp_value(temp_value), .sda_drive_low(sda_drive_low), .cfg_out(cfg_out),
    .set_lo(set_lo), .set_hi(set_hi), .rd_strobe(rd_strobe));

  always @(posedge clk) if (!rst && rd_strobe) strobes <= strobes + 1;

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H);
  endtask
  task automatic bus_stop;
    sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0;
    end
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2); ack = ~sda_line; wt(H/2); scl_m = 1'b0;
  endtask
  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2); b[i] = sda_line; wt(H/2); scl_m = 1'b0;
    end
    sda_m = ~give_ack; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0;
  endtask

  function automatic logic [7:0] addr_b(input logic rd);
    return {4'b1001, STRAP, rd};
  endfunction
  function automatic logic [7:0] exp_rd(input int k);
    logic [15:0] w;
    w = (m_ptr == 2'd0) ? temp_value : (m_ptr == 2'd2) ? m_lo : m_hi;
    if (m_ptr == 2'd1) return m_cfg;
    return (k % 2 == 0) ? w[15:8] : w[7:0];
  endfunction

  // write: pointer then n data bytes; the model follows the requirements
  task automatic do_write(input logic [7:0] p, input int n, input logic [23:0] d, input string req);
    logic ack; logic [7:0] stg = 8'h00;
    bus_start; send_byte(addr_b(1'b0), ack); chk({req, " addr ack R1"}, ack, 1'b1);
    send_byte(p, ack); chk({req, " ptr ack R2"}, ack, p <= 8'd3);
    if (p <= 8'd3) begin
      m_ptr = p[1:0];
      for (int k = 0; k < n; k++) begin
        logic [7:0] db; logic ok;
        db = d[23-8*k -: 8];
        ok = (p != 8'd0) && (k < ((p == 8'd1) ? 1 : 2));
        send_byte(db, ack); chk({req, " data ack R4 R5 R6"}, ack, ok);
        if (!ok) break;
        if (p == 8'd1) m_cfg = {1'b0, db[6:0]};
        else if (k == 0) stg = db;
        else if (p == 8'd2) m_lo = {stg, db};
        else m_hi = {stg, db};
      end
    end
    bus_stop;
    chk({req, " cfg R4"}, cfg_out, m_cfg);
    chk({req, " lo R5"}, set_lo, m_lo);
    chk({req, " hi R5"}, set_hi, m_hi);
    chk({req, " release R11"}, sda_drive_low, 1'b0);
  endtask

  task automatic do_read(input int n, input string req);
    logic ack; logic [7:0] b; int s0, exp_s;
    s0 = strobes;
    bus_start; send_byte(addr_b(1'b1), ack); chk({req, " addr ack R1"}, ack, 1'b1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk({req, " byte R7 R3"}, b, exp_rd(k));
    end
    bus_stop;
    exp_s = (m_ptr == 2'd1) ? n : n / 2;
    chk({req, " strobes R9"}, strobes - s0, exp_s);
    chk({req, " released R8"}, sda_drive_low, 1'b0);
  endtask

  initial begin
    logic ack; logic [7:0] b; int s0;
    wt(5);
    chk("reset drive R11", sda_drive_low, 1'b0);
    rst = 1'b0; wt(4);
    chk("reset cfg R4", cfg_out, 8'h00);
    chk("reset lo R5", set_lo, 16'h4B00);
    chk("reset hi R5", set_hi, 16'h5000);
    do_read(2, "temp after reset R3");
    // R1: wrong strap bits and wrong code
    bus_start; send_byte({4'b1001, 3'b000, 1'b1}, ack); chk("strap mismatch R1", ack, 1'b0);
    send_byte(8'h00, ack); chk("ignored after mismatch R1", ack, 1'b0); bus_stop;
    bus_start; send_byte({4'b1010, STRAP, 1'b0}, ack); chk("code mismatch R1", ack, 1'b0); bus_stop;
    do_write(8'h05, 0, 24'h0, "ptr out of range R2");
    do_read(2, "ptr unchanged R2");
    do_write(8'h01, 2, 24'hFF_AA00, "cfg write R4");
    do_read(2, "cfg repeat R7");
    do_write(8'h03, 1, 24'h12_0000, "half setpoint R5");
    do_write(8'h03, 3, 24'h12_3456, "full setpoint R5");
    do_write(8'h00, 1, 24'h77_0000, "temp write R6");
    do_write(8'h02, 0, 24'h0, "ptr only R3");
    do_read(2, "persist a R3");
    do_read(4, "persist b R3");
    // R7: temperature low byte stays paired with its high byte
    do_write(8'h00, 0, 24'h0, "temp select R7");
    temp_value = 16'hE6F0; s0 = strobes;
    bus_start; send_byte(addr_b(1'b1), ack);
    recv_byte(1'b1, b); chk("snap hi R7", b, 8'hE6);
    temp_value = 16'h0A20;
    recv_byte(1'b0, b); chk("snap lo R7", b, 8'hF0);
    chk("full read strobe R9", strobes - s0, 1);
    // R8: after a NACK the target leaves the line alone
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2); chk("nack release R8", sda_line, 1'b1);
    wt(H/2); scl_m = 1'b0; wt(H); bus_stop;
    // R9: partial read gives no pulse
    s0 = strobes;
    bus_start; send_byte(addr_b(1'b1), ack); recv_byte(1'b0, b); bus_stop;
    chk("partial read R9", strobes - s0, 0);
    chk("partial byte R7", b, 8'h0A);
    // R10: pointer write, repeated START, read
    bus_start; send_byte(addr_b(1'b0), ack); send_byte(8'h01, ack); m_ptr = 2'd1;
    chk("rs ptr ack R10", ack, 1'b1);
    bus_start; send_byte(addr_b(1'b1), ack); chk("rs addr ack R10", ack, 1'b1);
    recv_byte(1'b0, b); bus_stop; chk("rs cfg R10", b, m_cfg);
    // random mix
    void'($urandom(32'h5EED_0042));
    for (int it = 0; it < 40; it++) begin
      int op; op = $urandom_range(0, 2);
      if (op == 0) do_write(8'($urandom_range(0, 5)), $urandom_range(0, 3), 24'($urandom), "rand write");
      else if (op == 1) do_read($urandom_range(1, 3), "rand read");
      else temp_value = 16'($urandom);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R8 actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule